// File: doc/BRIEF.md
# NRZI Sector Read Decoder

This block turns the sampled read-back level of a magnetic track into characters. A bit-clock enable qualifies each sample, and sampling is limited to the window between a sector-open pulse and a sector-close pulse. The decoder recovers bits from level transitions. It hunts for the leading spacing bit of each character cell, collects the rest of the cell, checks parity and delivers the character.

Each recovered cell is eight bits long: a spacing bit of 1, six character bits, and a parity bit chosen so that the cell holds an odd number of ones. The decoder emits every character on a one-cycle strobe together with a parity-error flag. It counts the characters and parity failures of the current sector. When the sector closes it reports whether the sector held the expected number of characters and whether a cell was cut short.

Top module: `nrzi_sector_reader`

## Requirements
- R1: While the window is open, a sample taken with `bit_en` high decodes as bit 1 when its level differs from the previous accepted sample and as 0 when it is equal. The first sample after `sec_start` only loads the reference level and yields no bit.
- R2: While no cell is in progress, decoded 0 bits are discarded. The first decoded 1 is taken as the spacing bit and starts a cell.
- R3: A cell is the spacing bit followed by exactly seven more bits. The first bit after the spacing bit appears on `char_data[5]` and the next five on `char_data[4:0]` in order. The eighth bit is parity. Each finished cell raises `char_valid` for exactly one cycle.
- R4: `char_perr` is 1 with a cell whose eight bits contain an even number of ones and 0 otherwise. The character bits are delivered in both cases.
- R5: Samples with `bit_en` low, and all samples outside the sector window, have no effect on the decoded characters.
- R6: `char_count` counts the characters delivered since the last `sec_start`, saturating at 255. After a sector closes, `sector_full` is 1 exactly when the count equals CHARS_PER_SECTOR (default 100).
- R7: `err_count` counts parity failures, saturates at 255 and returns to 0 on every `sec_start`.
- R8: If the sector closes while a cell is partly collected, that cell is not delivered and `sector_trunc` is set until the next `sec_start`.
- R9: Each sector close produces one single-cycle `sector_done` pulse, after every character of that sector has been delivered.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_start | input | 1 | Pulse that opens a sector window |
| sec_end | input | 1 | Pulse that closes the sector window |
| bit_en | input | 1 | Bit-clock enable qualifying `rd_level` |
| rd_level | input | 1 | Sampled read-back level |
| char_valid | output | 1 | One-cycle strobe for a decoded character |
| char_data | output | 6 | Character bits, first received in bit 5 |
| char_perr | output | 1 | Parity failure of the delivered cell |
| char_count | output | 8 | Characters delivered in the current sector |
| err_count | output | 8 | Saturating parity-failure count |
| sector_done | output | 1 | One-cycle pulse once a sector has closed |
| sector_full | output | 1 | Sector held the expected character count |
| sector_trunc | output | 1 | A partial cell was dropped at sector close |

## Verification
A full sector of 100 characters has varied runs of 0 bits between cells, and some cells carry wrong parity. This sector separates correct hunting and framing from any off-by-one in the cell length, and it tests the count and full flag. A second sector gates samples with sparse enables and puts noise on the level between them. It also opens with a reference level opposite to the previous one, which exposes a false transition at window open and any sampling without the enable. A sector that ends mid-cell checks that the partial cell is dropped and flagged. A long sector of bad cells drives both counters into saturation, and level toggling between sectors must produce no characters.

// File: rtl/nrzi_rd_pkg.sv
package nrzi_rd_pkg;
  typedef enum logic {
    FR_HUNT    = 1'b0,
    FR_COLLECT = 1'b1
  } frame_st_e;
endpackage

// File: rtl/nrzi_bit_recover.sv
module nrzi_bit_recover (
  input  logic clk,
  input  logic rst,
  input  logic sec_start,
  input  logic sec_end,
  input  logic bit_en,
  input  logic rd_level,
  output logic bit_v,
  output logic bit_val,
  output logic end_v
);
  logic win_q;
  logic first_q;
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q   <= 1'b0;
      first_q <= 1'b0;
      prev_q  <= 1'b0;
      bit_v   <= 1'b0;
      bit_val <= 1'b0;
      end_v   <= 1'b0;
    end else begin
      bit_v <= 1'b0;
      end_v <= 1'b0;
      if (sec_start) begin
        win_q   <= 1'b1;
        first_q <= 1'b1;
      end else if (win_q && sec_end) begin
        win_q <= 1'b0;
        end_v <= 1'b1;
      end else if (win_q && bit_en) begin
        prev_q  <= rd_level;
        first_q <= 1'b0;
        if (!first_q) begin
          bit_v   <= 1'b1;
          bit_val <= rd_level ^ prev_q;
        end
      end
    end
  end
endmodule

// File: rtl/nrzi_cell_framer.sv
module nrzi_cell_framer #(
  parameter int CHAR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_start,
  input  logic              bit_v,
  input  logic              bit_val,
  input  logic              end_v,
  output logic              cell_v,
  output logic [CHAR_W-1:0] cell_data,
  output logic              cell_perr,
  output logic              cell_end,
  output logic              cell_trunc
);
  import nrzi_rd_pkg::*;

  localparam int CELL_W = CHAR_W + 2;
  localparam int IDX_W  = $clog2(CELL_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CELL_W - 1);

  frame_st_e          st_q;
  logic [CELL_W-1:0]  sr_q;
  logic [CELL_W-1:0]  sr_n;
  logic [IDX_W-1:0]   idx_q;

  always_comb sr_n = {sr_q[CELL_W-2:0], bit_val};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= FR_HUNT;
      sr_q       <= '0;
      idx_q      <= '0;
      cell_v     <= 1'b0;
      cell_data  <= '0;
      cell_perr  <= 1'b0;
      cell_end   <= 1'b0;
      cell_trunc <= 1'b0;
    end else begin
      cell_v   <= 1'b0;
      cell_end <= 1'b0;
      if (sec_start) begin
        st_q       <= FR_HUNT;
        idx_q      <= '0;
        cell_trunc <= 1'b0;
      end else if (end_v) begin
        cell_end   <= 1'b1;
        cell_trunc <= (st_q == FR_COLLECT);
        st_q       <= FR_HUNT;
        idx_q      <= '0;
      end else if (bit_v) begin
        if (st_q == FR_HUNT) begin
          if (bit_val) begin
            st_q  <= FR_COLLECT;
            sr_q  <= CELL_W'(1);
            idx_q <= IDX_W'(1);
          end
        end else begin
          sr_q <= sr_n;
          if (idx_q == IDX_LAST) begin
            cell_v    <= 1'b1;
            cell_data <= sr_n[CELL_W-2:1];
            cell_perr <= ~(^sr_n);
            st_q      <= FR_HUNT;
            idx_q     <= '0;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/nrzi_sector_tracker.sv
module nrzi_sector_tracker #(
  parameter int CHARS_PER_SECTOR = 100,
  parameter int CNT_W            = 8,
  parameter int ERR_W            = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sec_start,
  input  logic             cell_v,
  input  logic             cell_perr,
  input  logic             cell_end,
  input  logic             cell_trunc,
  output logic [CNT_W-1:0] char_count,
  output logic [ERR_W-1:0] err_count,
  output logic             sector_done,
  output logic             sector_full,
  output logic             sector_trunc
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_EXP = CNT_W'(CHARS_PER_SECTOR);

  always_ff @(posedge clk) begin
    if (rst) begin
      char_count   <= '0;
      err_count    <= '0;
      sector_done  <= 1'b0;
      sector_full  <= 1'b0;
      sector_trunc <= 1'b0;
    end else begin
      sector_done <= 1'b0;
      if (sec_start) begin
        char_count   <= '0;
        err_count    <= '0;
        sector_full  <= 1'b0;
        sector_trunc <= 1'b0;
      end else begin
        if (cell_v) begin
          if (char_count != CNT_MAX) char_count <= char_count + CNT_W'(1);
          if (cell_perr && err_count != ERR_MAX) err_count <= err_count + ERR_W'(1);
        end
        if (cell_end) begin
          sector_done  <= 1'b1;
          sector_full  <= (char_count == CNT_EXP);
          sector_trunc <= cell_trunc;
        end
      end
    end
  end
endmodule

// File: rtl/nrzi_sector_reader.sv
module nrzi_sector_reader #(
  parameter int CHAR_W           = 6,
  parameter int CHARS_PER_SECTOR = 100,
  parameter int CNT_W            = 8,
  parameter int ERR_W            = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_start,
  input  logic              sec_end,
  input  logic              bit_en,
  input  logic              rd_level,
  output logic              char_valid,
  output logic [CHAR_W-1:0] char_data,
  output logic              char_perr,
  output logic [CNT_W-1:0]  char_count,
  output logic [ERR_W-1:0]  err_count,
  output logic              sector_done,
  output logic              sector_full,
  output logic              sector_trunc
);
  logic bit_v, bit_val, end_v;
  logic cell_end, cell_trunc;

  nrzi_bit_recover i_recover (
    .clk(clk), .rst(rst), .sec_start(sec_start), .sec_end(sec_end),
    .bit_en(bit_en), .rd_level(rd_level),
    .bit_v(bit_v), .bit_val(bit_val), .end_v(end_v)
  );

  nrzi_cell_framer #(.CHAR_W(CHAR_W)) i_framer (
    .clk(clk), .rst(rst), .sec_start(sec_start),
    .bit_v(bit_v), .bit_val(bit_val), .end_v(end_v),
    .cell_v(char_valid), .cell_data(char_data), .cell_perr(char_perr),
    .cell_end(cell_end), .cell_trunc(cell_trunc)
  );

  nrzi_sector_tracker #(
    .CHARS_PER_SECTOR(CHARS_PER_SECTOR), .CNT_W(CNT_W), .ERR_W(ERR_W)
  ) i_tracker (
    .clk(clk), .rst(rst), .sec_start(sec_start),
    .cell_v(char_valid), .cell_perr(char_perr),
    .cell_end(cell_end), .cell_trunc(cell_trunc),
    .char_count(char_count), .err_count(err_count),
    .sector_done(sector_done), .sector_full(sector_full),
    .sector_trunc(sector_trunc)
  );
endmodule

// File: rtl/nrzi_sector_reader_chk.sv
module nrzi_sector_reader_chk #(
  parameter int CNT_W = 8,
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sec_start,
  input logic             char_valid,
  input logic             char_perr,
  input logic [CNT_W-1:0] char_count,
  input logic [ERR_W-1:0] err_count,
  input logic             sector_done
);
  p_valid_single_r3: assert property (@(posedge clk) disable iff (rst)
    char_valid |=> !char_valid);

  p_err_step_r7: assert property (@(posedge clk) disable iff (rst)
    (char_valid && char_perr && !sec_start && err_count != {ERR_W{1'b1}})
      |=> err_count == $past(err_count) + ERR_W'(1));

  p_err_sat_r7: assert property (@(posedge clk) disable iff (rst)
    (err_count == {ERR_W{1'b1}} && !sec_start) |=> err_count == {ERR_W{1'b1}});

  p_start_clear_r7: assert property (@(posedge clk) disable iff (rst)
    sec_start |=> (err_count == '0 && char_count == '0));

  p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
    (char_valid && !sec_start && char_count != {CNT_W{1'b1}})
      |=> char_count == $past(char_count) + CNT_W'(1));

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    sector_done |=> !sector_done);
endmodule

bind nrzi_sector_reader nrzi_sector_reader_chk #(.CNT_W(CNT_W), .ERR_W(ERR_W)) i_chk (.*);

// File: tb/test_nrzi_sector_reader.sv
module test_nrzi_sector_reader;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sec_start = 1'b0, sec_end = 1'b0, bit_en = 1'b0, rd_level = 1'b0;
  logic       char_valid, char_perr, sector_done, sector_full, sector_trunc;
  logic [5:0] char_data;
  logic [7:0] char_count, err_count;

  int checks = 0, failures = 0, done_cnt = 0, gap = 0;
  logic lvl = 1'b0;
  logic [6:0] exp_q[$];
  bit finished = 0;

  always #2 clk = ~clk;

  nrzi_sector_reader i_nrzi_sector_reader (.*);

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (sector_done) done_cnt++;
      if (char_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R5/R8 unexpected char", int'({char_perr, char_data}), -1);
        end else begin
          logic [6:0] e;
          e = exp_q.pop_front();
          check({char_perr, char_data} == e, "R3/R4 char+perr",
                int'({char_perr, char_data}), int'(e));
        end
      end
    end
  end

  task automatic sample(input logic en, input logic lv);
    @(negedge clk);
    bit_en   = en;
    rd_level = lv;
  endtask

  task automatic send_bit(input logic b);
    lvl = lvl ^ b;
    sample(1'b1, lvl);
    for (int g = 0; g < gap; g++) sample(1'b0, ~lvl);
  endtask

  task automatic send_char(input logic [5:0] d, input bit bad);
    logic par;
    par = ~(1'b1 ^ (^d));           // makes the cell odd
    if (bad) par = ~par;
    exp_q.push_back({bad ? 1'b1 : 1'b0, d});
    send_bit(1'b1);
    for (int k = 5; k >= 0; k--) send_bit(d[k]);
    send_bit(par);
  endtask

  task automatic open_sector(input logic ref_lv);
    @(negedge clk);
    bit_en = 1'b0; sec_start = 1'b1;
    @(negedge clk);
    sec_start = 1'b0;
    lvl = ref_lv;
    sample(1'b1, lvl);              // reference sample only (R1)
  endtask

  task automatic close_sector();
    @(negedge clk);
    bit_en = 1'b0; sec_end = 1'b1;
    @(negedge clk);
    sec_end = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int d0, errs;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check({char_valid, char_data, char_perr, char_count, err_count,
           sector_done, sector_full, sector_trunc} == '0, "R10 reset", 1, 0);

    // noise outside the window (R5)
    for (int i = 0; i < 20; i++) sample(1'b1, i[0]);

    // Sector A: 100 chars, zero runs between cells (R2), some bad parity
    errs = 0;
    d0 = done_cnt;
    open_sector(1'b1);
    for (int z = 0; z < 3; z++) send_bit(1'b0);
    for (int i = 0; i < 100; i++) begin
      bit bad;
      bad = (i % 10 == 4);
      if (bad) errs++;
      send_char(6'((i * 7 + 3) % 64), bad);
      for (int z = 0; z < i % 3; z++) send_bit(1'b0);
    end
    close_sector();
    check(exp_q.size() == 0, "R2/R3 all cells delivered", exp_q.size(), 0);
    check(char_count == 8'd100, "R6 count full sector", char_count, 100);
    check(sector_full == 1'b1, "R6 sector_full", sector_full, 1);
    check(sector_trunc == 1'b0, "R8 no trunc", sector_trunc, 0);
    check(err_count == 8'(errs), "R4/R7 err count", err_count, errs);
    check(done_cnt == d0 + 1, "R9 one done pulse", done_cnt, d0 + 1);

    // noise between sectors (R5)
    for (int i = 0; i < 30; i++) sample(1'b1, i[1]);

    // Sector B: sparse enables with noise, reference level flipped (R1, R5)
    gap = 2;
    d0 = done_cnt;
    open_sector(1'b0);
    @(negedge clk);
    check(err_count == 8'd0 && char_count == 8'd0, "R7 cleared on start", err_count, 0);
    send_bit(1'b0);
    send_char(6'd0, 0);
    send_char(6'd63, 1);
    send_char(6'd21, 0);
    send_char(6'd42, 1);
    send_char(6'd1, 0);
    close_sector();
    gap = 0;
    check(exp_q.size() == 0, "R1/R5 gapped cells", exp_q.size(), 0);
    check(char_count == 8'd5, "R6 count short sector", char_count, 5);
    check(sector_full == 1'b0, "R6 not full", sector_full, 0);
    check(err_count == 8'd2, "R7 err after clear", err_count, 2);
    check(done_cnt == d0 + 1, "R9 done pulse B", done_cnt, d0 + 1);

    // Sector C: partial cell at close (R8)
    open_sector(1'b1);
    send_char(6'd9, 0);
    send_char(6'd18, 0);
    send_char(6'd36, 0);
    send_bit(1'b1);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    close_sector();
    check(exp_q.size() == 0, "R8 partial dropped", exp_q.size(), 0);
    check(char_count == 8'd3, "R8 count excludes partial", char_count, 3);
    check(sector_trunc == 1'b1, "R8 trunc flag", sector_trunc, 1);

    // Sector D: saturation (R6, R7)
    open_sector(1'b0);
    for (int i = 0; i < 260; i++) send_char(6'(i % 64), 1);
    close_sector();
    check(err_count == 8'd255, "R7 err saturates", err_count, 255);
    check(char_count == 8'd255, "R6 count saturates", char_count, 255);
    check(sector_trunc == 1'b0, "R8 trunc cleared", sector_trunc, 0);
    check(exp_q.size() == 0, "R3 saturation cells", exp_q.size(), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule